// File: doc/BRIEF.md
# Line Voltage Sag Detector

This block watches a stream of signed two's-complement line-voltage samples together with a pulse that marks each zero crossing of that voltage. Between two crossings it keeps the largest sample magnitude. At each crossing it judges the half-cycle that just closed as low when that peak falls under a programmed level. It counts how many low half-cycles arrive in a row.

When the run of low half-cycles reaches a programmed length, the active-low sag output drops and a one-cycle event pulse is raised for an interrupt status bit. The output stays low until a half-cycle closes with its peak at or above the level. The active-low output is modelled here as a plain logic signal that idles high. The pad driver that would make it open-drain lies outside the block.

Top module: `line_sag_detector`

## Requirements
- R1: While reset is asserted and after it is released, sag_n is 1 and sag_event is 0. The run count and the held peak both start at zero.
- R2: A half-cycle's peak is the largest magnitude among the samples with smp_valid=1 after the previous zc_pulse cycle, up to and including the cycle before the closing zc_pulse. A sample presented in a zc_pulse cycle belongs to the next half-cycle. Samples with smp_valid=0 are ignored.
- R3: Sample magnitude is the two's-complement absolute value. The most negative code, -2^(W-1), has magnitude 2^(W-1).
- R4: A closed half-cycle counts as low only when its peak is strictly less than sag_level. A peak equal to sag_level is not low.
- R5: Low half-cycles in a row increment the run count. Any closed half-cycle that is not low clears the count.
- R6: When a zc_pulse closes the low half-cycle that brings the run count to sag_cycles, sag_n goes to 0 and sag_event is 1 for exactly one cycle. Both changes appear in the cycle that follows the clock edge sampling that zc_pulse.
- R7: A sag_cycles value of 0 acts as 1.
- R8: Further low half-cycles after the sag is declared keep sag_n at 0 and raise no further sag_event.
- R9: A zc_pulse closing a half-cycle that is not low, while sag_n is 0, returns sag_n to 1 in the following cycle.
- R10: In cycles without zc_pulse, sag_n keeps its value and sag_event is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | smp_data carries a new sample this cycle |
| smp_data | input | SMP_W | Signed line-voltage sample |
| zc_pulse | input | 1 | One-cycle zero-crossing marker that closes a half-cycle |
| sag_level | input | SMP_W | Unsigned magnitude threshold |
| sag_cycles | input | CNT_W | Number of low half-cycles needed (0 acts as 1) |
| sag_n | output | 1 | Active-low sag indication, idles high |
| sag_event | output | 1 | One-cycle pulse when a sag is declared |

## Verification
A peak register that fails to clear at a crossing, or that picks up invalid or same-cycle samples, shifts the verdict on a half-cycle. That shows up as sag_n falling or releasing at the wrong crossing, and it is visible one cycle after the closing zc_pulse. A run count that is off by one, or that is not cleared by a good half-cycle, moves the sag_event pulse by a whole half-cycle. A stuck count either repeats the pulse or never raises it. The bench follows every cycle with a model of the requirements. It therefore sees these faults at the first crossing where the design and the model disagree, across both directed boundary halves and random amplitudes.

// File: rtl/sag_pkg.sv
package sag_pkg;
  // Outcome of one closed half-cycle.
  typedef struct packed {
    logic done;  // a half-cycle closed this cycle
    logic low;   // its peak was under the level
  } hc_verdict_t;
endpackage

// File: rtl/sag_peak_tracker.sv
module sag_peak_tracker
  import sag_pkg::*;
#(
  parameter int SMP_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_data,
  input  logic                    zc_pulse,
  input  logic        [SMP_W-1:0] sag_level,
  output hc_verdict_t             verdict
);
  logic [SMP_W-1:0] raw;
  logic [SMP_W-1:0] mag;
  logic [SMP_W-1:0] peak_q, peak_d;

  // Two's-complement magnitude; the most negative code maps to 2^(W-1).
  always_comb begin
    raw = smp_data;
    mag = raw[SMP_W-1] ? (~raw + 1'b1) : raw;
  end

  always_comb begin
    peak_d = peak_q;
    if (zc_pulse) begin
      // A sample arriving with the crossing opens the new half-cycle.
      peak_d = smp_valid ? mag : '0;
    end else if (smp_valid && (mag > peak_q)) begin
      peak_d = mag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) peak_q <= '0;
    else        peak_q <= peak_d;
  end

  always_comb begin
    verdict.done = zc_pulse;
    verdict.low  = (peak_q < sag_level);
  end

  assert_peak_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !zc_pulse |=> (peak_q >= $past(peak_q)));
  assert_peak_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_pulse && !smp_valid) |=> (peak_q == '0));
endmodule

// File: rtl/sag_run_counter.sv
module sag_run_counter
  import sag_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hc_verdict_t      verdict,
  input  logic [CNT_W-1:0] sag_cycles,
  output logic             run_hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] target;

  always_comb begin
    target = (sag_cycles == '0) ? ONE : sag_cycles;
    // Hit only on the transition into the target, so a run pulses once.
    run_hit = verdict.done && verdict.low && (cnt_q == (target - ONE));
  end

  always_comb begin
    cnt_d = cnt_q;
    if (verdict.done) begin
      if (!verdict.low)          cnt_d = '0;
      else if (cnt_q != CNT_MAX) cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_count_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict.done |=> $stable(cnt_q));
  assert_count_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict.done && !verdict.low) |=> (cnt_q == '0));
endmodule

// File: rtl/sag_flag_ctrl.sv
module sag_flag_ctrl
  import sag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  hc_verdict_t verdict,
  input  logic        run_hit,
  output logic        sag_n,
  output logic        sag_event
);
  logic act_q, act_d;
  logic evt_q, evt_d;

  always_comb begin
    act_d = act_q;
    if (run_hit)                         act_d = 1'b1;
    else if (verdict.done && !verdict.low) act_d = 1'b0;
    evt_d = run_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      act_q <= act_d;
      evt_q <= evt_d;
    end
  end

  assign sag_n     = ~act_q;
  assign sag_event = evt_q;

  assert_event_with_sag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sag_event |-> !sag_n);
  assert_fall_has_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sag_n) |-> sag_event);
  assert_single_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sag_event |=> !sag_event);
  assert_release_at_crossing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sag_n) |-> $past(verdict.done));
endmodule

// File: rtl/line_sag_detector.sv
module line_sag_detector
  import sag_pkg::*;
#(
  parameter int SMP_W = 16,
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_data,
  input  logic                    zc_pulse,
  input  logic        [SMP_W-1:0] sag_level,
  input  logic        [CNT_W-1:0] sag_cycles,
  output logic                    sag_n,
  output logic                    sag_event
);
  hc_verdict_t verdict;
  logic        run_hit;

  sag_peak_tracker #(.SMP_W(SMP_W)) u_peak (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .zc_pulse(zc_pulse), .sag_level(sag_level), .verdict(verdict)
  );

  sag_run_counter #(.CNT_W(CNT_W)) u_run (
    .clk(clk), .rst_n(rst_n), .verdict(verdict), .sag_cycles(sag_cycles),
    .run_hit(run_hit)
  );

  sag_flag_ctrl u_flag (
    .clk(clk), .rst_n(rst_n), .verdict(verdict), .run_hit(run_hit),
    .sag_n(sag_n), .sag_event(sag_event)
  );

  assert_quiet_without_crossing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !zc_pulse |=> ($stable(sag_n) && !sag_event));
endmodule

// File: tb/line_sag_detector_bench.sv
module line_sag_detector_bench;
  localparam int SMP_W = 16;
  localparam int CNT_W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    smp_valid;
  logic signed [SMP_W-1:0] smp_data;
  logic                    zc_pulse;
  logic        [SMP_W-1:0] sag_level;
  logic        [CNT_W-1:0] sag_cycles;
  logic                    sag_n;
  logic                    sag_event;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Reference model state
  int m_peak, m_cnt;
  bit m_act, e_evt;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_sag_detector #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_line_sag_detector (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .zc_pulse(zc_pulse), .sag_level(sag_level), .sag_cycles(sag_cycles),
    .sag_n(sag_n), .sag_event(sag_event)
  );

  function automatic int magnitude(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, advance the model, check at next negedge.
  task automatic step(input bit v, input int d, input bit zc, input string tag);
    int mg, tgt, maxc;
    bit low, hit;
    smp_valid = v;
    smp_data  = SMP_W'(d);
    zc_pulse  = zc;
    mg   = magnitude(d);
    maxc = (1 << CNT_W) - 1;
    if (zc) begin
      low = (m_peak < int'(sag_level));           // R4 strict compare
      tgt = (sag_cycles == 0) ? 1 : int'(sag_cycles); // R7
      hit = low && (m_cnt == tgt - 1);
      m_cnt = low ? ((m_cnt == maxc) ? maxc : m_cnt + 1) : 0; // R5
      e_evt = hit;
      if (hit) m_act = 1'b1;
      else if (!low) m_act = 1'b0;                // R9
      m_peak = v ? mg : 0;                        // R2 same-cycle sample opens next half
    end else begin
      e_evt = 1'b0;                               // R10
      if (v && mg > m_peak) m_peak = mg;
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " sag_n"}, int'(sag_n), int'(!m_act));
    check({tag, " sag_event"}, int'(sag_event), int'(e_evt));
  endtask

  // A half-cycle whose valid peak is exactly pk, then the closing crossing.
  task automatic half(input int pk, input int n, input bit junk, input string tag);
    int pos = $urandom_range(n - 1, 0);
    for (int i = 0; i < n; i++) begin
      int val;
      if (i == pos) val = ($urandom_range(1, 0) != 0) ? -pk : pk;
      else          val = int'($urandom_range(pk, 0)) * (($urandom_range(1, 0) != 0) ? -1 : 1);
      if (pk == 32768 && val == 32768) val = -32768;
      step(1'b1, val, 1'b0, tag);
      if (junk) step(1'b0, 32767, 1'b0, {tag, " R2 invalid"});
    end
    step(1'b1, int'($urandom_range(50, 0)), 1'b1, tag);
  endtask

  task automatic half_sp(input int pk, input string tag);
    half(pk, 4, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; smp_valid = 0; smp_data = '0; zc_pulse = 0;
    sag_level = 16'd1000; sag_cycles = 8'd3;
    m_peak = 0; m_cnt = 0; m_act = 0; e_evt = 0;
    repeat (3) @(negedge clk);
    check("R1 reset sag_n", int'(sag_n), 1);
    check("R1 reset sag_event", int'(sag_event), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset sag_n", int'(sag_n), 1);

    // Clear the half-cycle opened by reset (R1 peak zero -> counts as low).
    half_sp(2000, "R1 first half");
    // R5: two low, one good, then three low to trigger (R6).
    half_sp(500, "R5 low1");
    half_sp(999, "R5 low2");
    half_sp(1500, "R5 good clears");
    half_sp(100, "R5 low a");
    half_sp(900, "R5 low b");
    half_sp(999, "R6 low c triggers");
    // R8: more low, no new event.
    half_sp(10, "R8 still low");
    half_sp(20, "R8 still low");
    // R4: equal to the level is not low -> release (R9).
    half_sp(1000, "R4 R9 equal releases");
    // R10: idle cycles without crossing.
    for (int i = 0; i < 5; i++) step(1'b0, 0, 1'b0, "R10 idle");

    // R7: duration zero acts as one.
    sag_cycles = 8'd0;
    half_sp(300, "R7 single low triggers");
    half_sp(3000, "R7 R9 release");

    // R2: large invalid samples ignored.
    sag_cycles = 8'd1;
    half(400, 5, 1'b1, "R2 invalid junk ignored");
    half_sp(5000, "R2 release");

    // R3: most negative code has magnitude 2^(W-1).
    sag_level = 16'd32768;
    half_sp(32767, "R3 max positive is low");
    half_sp(32768, "R3 most negative not low");
    half_sp(32767, "R3 low again");
    half_sp(32768, "R3 release");

    // Random mix around the level.
    for (int k = 0; k < 400; k++) begin
      if ((k % 25) == 0) begin
        sag_level  = SMP_W'($urandom_range(20000, 100));
        sag_cycles = CNT_W'($urandom_range(4, 0));
      end
      half(int'($urandom_range(int'(sag_level) + 200, 0)) % 32768,
           int'($urandom_range(6, 1)), ($urandom_range(3, 0) == 0), "R5 R6 R8 R9 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule